// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a synthesizable behavioural model of a 256-byte nonvolatile memory that sits on an open-drain two-wire bus as a slave. It oversamples the bus clock and data lines on a fast system clock and finds START and STOP conditions. It matches the device address byte and acknowledges each byte it accepts. It supports byte writes, page writes that wrap inside an 8-byte page, current-address reads, random reads and sequential reads that wrap across the whole array.

The data line is modelled as a pull-down enable plus a sampled input. The bus master sets the pace through the clock line, and the block never stretches the clock. So the only back-pressure on the data stream is the acknowledge bit. A byte that gets no ACK was not taken. A master NACK on read data ends the stream. After any STOP that closes an unprotected write, the block runs a self-timed busy period of a programmable number of system clocks. During that period it ignores the bus, so a master can poll for completion by sending address bytes until one is acknowledged. A write-protect input keeps the array from changing.

Top module: `tws_eeprom`

## Requirements
- R1: The block answers a device address byte whose upper four bits are 1010. It ignores bits 3..1, and bit 0 selects read (1) or write (0). It acknowledges a matching byte by pulling SDA low during the ninth clock. A non-matching byte gets no ACK, and the block ignores the bus until the next START.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. The block changes its SDA pull-down only after it has detected a falling SCL edge, a START or a STOP.
- R3: A write header, then a word address byte, then a data byte stores that byte at that address. The block acknowledges every byte of this sequence.
- R4: During a write, only the low three bits of the address counter advance after each data byte. The counter wraps to the first byte of the same 8-byte page, so a ninth byte overwrites the first.
- R5: A STOP that follows at least one accepted, unprotected data byte starts a busy period of BUSY_CYCLES clocks. While it lasts, no address byte is acknowledged and the array is never written. After it ends, acknowledges resume.
- R6: While wp_i is high, data bytes are still acknowledged, but the array keeps its contents and the closing STOP starts no busy period.
- R7: A STOP that follows only a word address byte loads the address counter and starts no busy period.
- R8: A read header with no word address returns the byte at the address counter. The counter holds the last accessed address plus one.
- R9: A write header with a word address, followed by a repeated START and a read header, returns the byte at that word address.
- R10: In a read, each byte the master ACKs is followed by the byte at the next address, wrapping from 0xFF to 0x00. After a master NACK the block releases SDA.
- R11: After reset, SDA is released and the block is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level, as resolved on the wire |
| wp_i | input | 1 | Write protect: high keeps the array unchanged |
| sda_pull_o | output | 1 | High pulls the data line low (open-drain drive) |

## Verification
The hardest situation to reach from the ports is the busy window after a write. Nothing outputs it directly, and the only way to see it is a device address byte that goes unacknowledged. The stimulus closes a write with STOP and polls at once to find the silence. It then waits past the programmed cycle count and polls again to find the ACK. The page-wrap and array-wrap cases are reached with an over-long page write that starts near the end of a page, and with a sequential read that starts at 0xFF. The write-protect case uses the same poll to show that no busy window opened.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_ACK,
    PH_TX,
    PH_RACK
  } phase_t;

  typedef enum logic [1:0] {
    BK_DEV,
    BK_WADDR,
    BK_DATA
  } byte_kind_t;

  localparam logic [3:0] DEV_TAG = 4'b1010;
endpackage

// File: rtl/tws_line_sampler.sv
module tws_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sh;
  logic [SYNC_STAGES-1:0] sda_sh;
  logic scl_q;
  logic sda_q;
  logic scl_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_sh[SYNC_STAGES-1];
      sda_q  <= sda_sh[SYNC_STAGES-1];
    end
  end

  assign scl_now   = scl_sh[SYNC_STAGES-1];
  assign sda_s     = sda_sh[SYNC_STAGES-1];
  assign scl_rise  = scl_now & ~scl_q;
  assign scl_fall  = ~scl_now & scl_q;
  assign start_det = scl_now & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_now & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/tws_store.sv
module tws_store #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/tws_write_timer.sv
module tws_write_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             remain <= '0;
    else if (kick)          remain <= CW'(CYCLES);
    else if (remain != '0)  remain <= remain - CW'(1);
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
  import tws_pkg::*;
#(
  parameter int AW      = 8,
  parameter int PAGE_AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          busy,
  input  logic          wp,
  input  logic [7:0]    rdata,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          wr_kick,
  output logic          sda_pull
);
  phase_t     phase;
  byte_kind_t kind;
  logic [3:0] bitcnt;
  logic [7:0] sh;
  logic [AW-1:0] ptr;
  logic is_read;
  logic ninth;
  logic rack_ok;
  logic wr_pend;
  logic byte_done;

  assign byte_done = (phase == PH_RX) && scl_rise && (bitcnt == 4'd7)
                     && !start_det && !stop_det;
  assign mem_we    = byte_done && (kind == BK_DATA) && !wp;
  assign mem_wdata = {sh[6:0], sda_s};
  assign mem_addr  = ptr;
  assign wr_kick   = stop_det && wr_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      kind     <= BK_DEV;
      bitcnt   <= '0;
      sh       <= '0;
      ptr      <= '0;
      is_read  <= 1'b0;
      ninth    <= 1'b0;
      rack_ok  <= 1'b0;
      wr_pend  <= 1'b0;
      sda_pull <= 1'b0;
    end else if (start_det) begin
      sda_pull <= 1'b0;
      bitcnt   <= '0;
      kind     <= BK_DEV;
      phase    <= busy ? PH_IDLE : PH_RX;
    end else if (stop_det) begin
      sda_pull <= 1'b0;
      wr_pend  <= 1'b0;
      phase    <= PH_IDLE;
    end else begin
      case (phase)
        PH_RX: begin
          if (scl_rise) begin
            sh     <= {sh[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
            if (bitcnt == 4'd7) begin
              ninth <= 1'b0;
              case (kind)
                BK_DEV: begin
                  if (sh[6:3] == DEV_TAG) begin
                    is_read <= sda_s;
                    phase   <= PH_ACK;
                  end else begin
                    phase   <= PH_IDLE;
                  end
                end
                BK_WADDR: begin
                  ptr   <= AW'({sh[6:0], sda_s});
                  phase <= PH_ACK;
                end
                default: begin
                  ptr   <= {ptr[AW-1:PAGE_AW], ptr[PAGE_AW-1:0] + PAGE_AW'(1)};
                  if (!wp) wr_pend <= 1'b1;
                  phase <= PH_ACK;
                end
              endcase
            end
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            if (!ninth) begin
              sda_pull <= 1'b1;
              ninth    <= 1'b1;
            end else if (kind == BK_DEV && is_read) begin
              ptr      <= ptr + AW'(1);
              sh       <= {rdata[6:0], 1'b0};
              sda_pull <= ~rdata[7];
              bitcnt   <= '0;
              phase    <= PH_TX;
            end else begin
              sda_pull <= 1'b0;
              bitcnt   <= '0;
              kind     <= (kind == BK_DEV) ? BK_WADDR : BK_DATA;
              phase    <= PH_RX;
            end
          end
        end
        PH_TX: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_pull <= 1'b0;
              rack_ok  <= 1'b0;
              phase    <= PH_RACK;
            end else begin
              sda_pull <= ~sh[7];
              sh       <= {sh[6:0], 1'b0};
            end
          end
        end
        PH_RACK: begin
          if (scl_rise) begin
            if (sda_s) phase <= PH_IDLE;
            else       rack_ok <= 1'b1;
          end else if (scl_fall && rack_ok) begin
            ptr      <= ptr + AW'(1);
            sh       <= {rdata[6:0], 1'b0};
            sda_pull <= ~rdata[7];
            bitcnt   <= '0;
            phase    <= PH_TX;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tws_eeprom.sv
module tws_eeprom #(
  parameter int BUSY_CYCLES = 1000,
  parameter int SYNC_STAGES = 2,
  parameter int AW          = 8,
  parameter int PAGE_AW     = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_pull_o
);
  logic sda_s;
  logic scl_rise;
  logic scl_fall;
  logic start_det;
  logic stop_det;
  logic wr_busy;
  logic wr_kick;
  logic mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata;

  tws_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  tws_ctrl #(.AW(AW), .PAGE_AW(PAGE_AW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .busy(wr_busy), .wp(wp_i), .rdata(mem_rdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .wr_kick(wr_kick), .sda_pull(sda_pull_o)
  );

  tws_store #(.AW(AW), .DW(8)) u_mem (
    .clk(clk), .we(mem_we), .addr(mem_addr),
    .wdata(mem_wdata), .rdata(mem_rdata)
  );

  tws_write_timer #(.CYCLES(BUSY_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .kick(wr_kick), .busy(wr_busy)
  );
endmodule

// File: rtl/tws_eeprom_chk.sv
module tws_eeprom_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_fall,
  input logic start_det,
  input logic stop_det,
  input logic busy,
  input logic mem_we,
  input logic sda_pull
);
  assert_drive_after_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> $past(scl_fall || start_det || stop_det));

  assert_silent_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_pull);

  assert_busy_from_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det));

  assert_no_write_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !busy);

  assert_released_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !sda_pull);
endmodule

bind tws_eeprom tws_eeprom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall),
  .start_det(start_det), .stop_det(stop_det),
  .busy(wr_busy), .mem_we(mem_we), .sda_pull(sda_pull_o)
);

// File: tb/sim_tws_eeprom.sv
`timescale 1ns/1ps
module sim_tws_eeprom;
  localparam int BUSY = 600;
  localparam int H    = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic wp = 1'b0;
  logic sda_pull;
  logic sda_line;

  int checks = 0;
  int errors = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got_v;
  event       rd_ev;

  always #2 clk = ~clk;

  assign sda_line = m_sda & ~sda_pull;

  tws_eeprom #(.BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .wp_i(wp), .sda_pull_o(sda_pull)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp_v);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wclk(4);
    m_scl = 1'b1; wclk(H);
    m_sda = 1'b0; wclk(H);
    m_scl = 1'b0; wclk(4);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wclk(4);
    m_scl = 1'b1; wclk(H);
    m_sda = 1'b1; wclk(H);
  endtask

  task automatic send_bit(input logic b);
    wclk(H/2); m_sda = b; wclk(H/2);
    m_scl = 1'b1; wclk(H);
    m_scl = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; wclk(H);
    m_scl = 1'b1; wclk(H/2);
    ack = ~sda_line;
    wclk(H/2);
    m_scl = 1'b0;
  endtask

  task automatic read_byte(input logic master_ack, output logic [7:0] v);
    logic a, b;
    m_sda = 1'b1;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      wclk(H); m_scl = 1'b1; wclk(2);
      a = sda_line; wclk(H-4);
      b = sda_line;
      chk(a == b, "R2 data stable while SCL high", b, a);
      wclk(2); m_scl = 1'b0;
      v = {v[6:0], a};
    end
    send_bit(master_ack ? 1'b0 : 1'b1);
    m_sda = 1'b1;
    got_v = v;
    -> rd_ev;
  endtask

  task automatic poll(output logic ack);
    bus_start();
    write_byte(8'hA0, ack);
    bus_stop();
  endtask

  task automatic byte_wr(input logic [7:0] addr, input logic [7:0] d, input string tag);
    logic ack;
    bus_start();
    write_byte(8'hA0, ack); chk(ack, tag, ack, 1);
    write_byte(addr, ack);  chk(ack, tag, ack, 1);
    write_byte(d, ack);     chk(ack, tag, ack, 1);
    bus_stop();
  endtask

  task automatic read_n(input int n);
    logic [7:0] v;
    for (int i = 0; i < n; i++) read_byte(i < n - 1, v);
    wclk(6);
    chk(sda_line == 1'b1, "R10 SDA released after NACK", sda_line, 1);
    bus_stop();
  endtask

  task automatic rand_read(input logic [7:0] addr, input int n, input string tag);
    logic ack;
    bus_start();
    write_byte(8'hA0, ack); chk(ack, tag, ack, 1);
    write_byte(addr, ack);  chk(ack, tag, ack, 1);
    bus_start();
    write_byte(8'hA1, ack); chk(ack, tag, ack, 1);
    read_n(n);
  endtask

  task automatic cur_read(input int n, input string tag);
    logic ack;
    bus_start();
    write_byte(8'hA1, ack); chk(ack, tag, ack, 1);
    read_n(n);
  endtask

  task automatic expect_byte(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  initial begin : monitor
    logic [7:0] e;
    string t;
    forever begin
      @(rd_ev);
      if (exp_q.size() == 0) begin
        chk(1'b0, "scoreboard unexpected byte", got_v, 0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(got_v == e, t, got_v, e);
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic ack;
    wclk(10);
    rst_n = 1'b1;
    wclk(6);
    chk(sda_pull == 1'b0, "R11 reset releases SDA", sda_pull, 0);

    poll(ack);
    chk(ack, "R11 not busy after reset / R1 match", ack, 1);

    // R1: wrong upper nibble gets no ACK, following byte ignored
    bus_start();
    write_byte(8'hB0, ack); chk(!ack, "R1 mismatch not acked", ack, 0);
    write_byte(8'h10, ack); chk(!ack, "R1 ignored until START", ack, 0);
    bus_stop();
    // R1: bits 3..1 are don't-care
    bus_start();
    write_byte(8'hAE, ack); chk(ack, "R1 bits 3..1 ignored", ack, 1);
    bus_stop();

    // R3 byte write, R5 busy polling
    byte_wr(8'h10, 8'h5A, "R3 byte write ack");
    poll(ack); chk(!ack, "R5 silent while busy", ack, 0);
    wclk(BUSY);
    poll(ack); chk(ack, "R5 ack after busy", ack, 1);

    // R9 random read
    expect_byte(8'h5A, "R9 random read data");
    rand_read(8'h10, 1, "R9 header ack");

    // R4 page write wrap: 10 bytes from 0x1D
    bus_start();
    write_byte(8'hA0, ack); chk(ack, "R4 header", ack, 1);
    write_byte(8'h1D, ack); chk(ack, "R4 address", ack, 1);
    for (int i = 0; i < 10; i++) begin
      write_byte(8'hC0 + 8'(i), ack);
      chk(ack, "R4 data ack", ack, 1);
    end
    bus_stop();
    wclk(BUSY + 50);
    for (int i = 3; i < 10; i++) expect_byte(8'hC0 + 8'(i), "R4 page wrap content");
    rand_read(8'h18, 7, "R4 read header");

    // R8 current address read continues at 0x1F
    expect_byte(8'hC2, "R8 current address read");
    cur_read(1, "R8 header");

    // R7 address-only write: no busy, counter loaded
    bus_start();
    write_byte(8'hA0, ack); chk(ack, "R7 header", ack, 1);
    write_byte(8'h1A, ack); chk(ack, "R7 address", ack, 1);
    bus_stop();
    poll(ack); chk(ack, "R7 no busy after address-only", ack, 1);
    expect_byte(8'hC5, "R7 counter loaded");
    cur_read(1, "R7 read header");

    // R10 sequential wrap across the array
    byte_wr(8'hFF, 8'h77, "R10 setup");
    wclk(BUSY + 50);
    byte_wr(8'h00, 8'h88, "R10 setup");
    wclk(BUSY + 50);
    expect_byte(8'h77, "R10 byte at 0xFF");
    expect_byte(8'h88, "R10 wrap to 0x00");
    rand_read(8'hFF, 2, "R10 header");

    // R6 write protect
    wp = 1'b1;
    byte_wr(8'h10, 8'hEE, "R6 protected bytes acked");
    poll(ack); chk(ack, "R6 no busy when protected", ack, 1);
    expect_byte(8'h5A, "R6 array unchanged");
    rand_read(8'h10, 1, "R6 header");
    wp = 1'b0;

    wclk(20);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule